// File: doc/BRIEF.md
# Byte-Masked Rotate-Merge Unit

This unit is a one-stage 32-bit datapath for a small packet-processing engine. Each accepted request rotates a source word left by a 5-bit amount. It then either writes the rotated word whole, which is the move operation, or writes only the byte lanes chosen by a 4-bit lane mask, which is the field-load operation. In a field load, every lane not chosen keeps the value of the current destination word that comes in with the request. The new destination value appears on a registered output together with a valid strobe.

Two back-to-back requests on the same source and destination can reverse the byte order of a longword. This converts network (big-endian) order into the engine's little-endian order. The first request is a move rotated left by 8. The second is a field load rotated left by 24, with lanes 3 and 1 selected, and it takes the first result as its destination. The register file, decode, flags and memory access are outside this unit.

Top module: `rotmerge_unit`

## Requirements
- R1: While `rst` is high at a clock edge, `res_valid` and `res_word` are cleared to 0 on that edge.
- R2: A request with `req_op` = 0 (move) produces `res_word` equal to `src_word` rotated left by `req_rot`. `req_mask` and `dst_word` have no effect on a move.
- R3: The rotation is circular for every amount from 0 to 31 and loses no bits. An amount of 0 passes the source through unchanged.
- R4: A request with `req_op` = 1 (field load) sets byte lane i (bits 8i+7..8i) of `res_word` to lane i of the rotated source when `req_mask[i]` is 1. When `req_mask[i]` is 0, lane i takes lane i of `dst_word`. Written most significant lane first, mask 1010 selects lanes 3 and 1.
- R5: A field load with mask 0000 returns `dst_word` unchanged.
- R6: A field load with mask 1111 returns the same word as a move with the same source and amount.
- R7: `res_valid` is high on the clock edge after each edge that samples `req_valid` high. A new request is accepted on every cycle.
- R8: On an edge that samples `req_valid` low, `res_valid` goes low and `res_word` keeps its previous value, whatever the other inputs carry.
- R9: A move rotated left by 8 followed by a field load rotated left by 24 with mask 1010, both from the same source and with the first result as the second's destination, yields the byte-reversed source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 1 | 0 = rotate move, 1 = masked field load |
| req_rot | input | 5 | Left-rotate amount |
| req_mask | input | 4 | Byte-lane select for field load, bit i = lane i |
| src_word | input | 32 | Source operand |
| dst_word | input | 32 | Current destination value |
| res_valid | output | 1 | Result strobe, one cycle after the request |
| res_word | output | 32 | New destination value |

## Verification
Moves are tried with single-bit and byte-distinct words at every rotate amount from 0 to 31. A single set bit shows whether each barrel stage shifts by the right power of two. Distinct bytes show whether wrap-around keeps every bit. Field loads sweep all sixteen masks against a destination whose bytes differ from every byte of the source, so each lane shows whether it came from the rotated source or from the destination, and a swapped or stuck lane select is exposed. The two-operation swap on random words, back-to-back requests, and idle cycles with changing inputs separate correct latency and hold behaviour from results that are off by one cycle or not held.

// File: rtl/rotmerge_pkg.sv
package rotmerge_pkg;

    localparam int unsigned RM_WORD_W = 32;
    localparam int unsigned RM_LANE_W = 8;
    localparam int unsigned RM_LANES  = RM_WORD_W / RM_LANE_W;
    localparam int unsigned RM_ROT_W  = $clog2(RM_WORD_W);

    typedef enum logic {
        OP_MOVE  = 1'b0,
        OP_FIELD = 1'b1
    } rm_op_e;

    typedef struct packed {
        rm_op_e                 op;
        logic [RM_ROT_W-1:0]    rot;
        logic [RM_LANES-1:0]    mask;
        logic [RM_WORD_W-1:0]   src;
        logic [RM_WORD_W-1:0]   dst;
    } rm_req_t;

    typedef struct packed {
        logic                   valid;
        logic [RM_WORD_W-1:0]   word;
    } rm_res_t;

    // Lane select actually applied: a move writes every lane.
    function automatic logic [RM_LANES-1:0] rm_lane_sel(input rm_op_e op,
                                                        input logic [RM_LANES-1:0] mask);
        return (op == OP_FIELD) ? mask : {RM_LANES{1'b1}};
    endfunction

endpackage

// File: rtl/rotmerge_rotator.sv
module rotmerge_rotator #(
    parameter int unsigned WORD_W = rotmerge_pkg::RM_WORD_W,
    parameter int unsigned ROT_W  = $clog2(WORD_W)
) (
    input  logic [WORD_W-1:0] data_in,
    input  logic [ROT_W-1:0]  amount,
    output logic [WORD_W-1:0] data_out
);

    logic [WORD_W-1:0] stage [0:ROT_W];

    assign stage[0] = data_in;

    // Log barrel: stage k rotates left by 2**k when amount bit k is set.
    for (genvar k = 0; k < ROT_W; k++) begin : g_stage
        localparam int unsigned SH = 1 << k;
        assign stage[k+1] = amount[k]
            ? {stage[k][WORD_W-1-SH:0], stage[k][WORD_W-1 -: SH]}
            : stage[k];
    end

    assign data_out = stage[ROT_W];

endmodule

// File: rtl/rotmerge_lane_merge.sv
module rotmerge_lane_merge #(
    parameter int unsigned WORD_W = rotmerge_pkg::RM_WORD_W,
    parameter int unsigned LANE_W = rotmerge_pkg::RM_LANE_W,
    parameter int unsigned LANES  = WORD_W / LANE_W
) (
    input  logic [WORD_W-1:0] take_word,
    input  logic [WORD_W-1:0] keep_word,
    input  logic [LANES-1:0]  lane_sel,
    output logic [WORD_W-1:0] merged
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        assign merged[l*LANE_W +: LANE_W] = lane_sel[l]
            ? take_word[l*LANE_W +: LANE_W]
            : keep_word[l*LANE_W +: LANE_W];
    end

endmodule

// File: rtl/rotmerge_unit.sv
module rotmerge_unit
    import rotmerge_pkg::*;
#(
    parameter int unsigned WORD_W = RM_WORD_W,
    parameter int unsigned LANE_W = RM_LANE_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_op,
    input  logic [$clog2(WORD_W)-1:0]   req_rot,
    input  logic [WORD_W/LANE_W-1:0]    req_mask,
    input  logic [WORD_W-1:0]           src_word,
    input  logic [WORD_W-1:0]           dst_word,
    output logic                        res_valid,
    output logic [WORD_W-1:0]           res_word
);

    localparam int unsigned LANES = WORD_W / LANE_W;
    localparam int unsigned ROT_W = $clog2(WORD_W);

    rm_op_e            op_q;
    logic [LANES-1:0]  lane_sel;
    logic [WORD_W-1:0] rot_word;
    logic [WORD_W-1:0] merge_word;
    logic              valid_r;
    logic [WORD_W-1:0] word_r;

    assign op_q     = rm_op_e'(req_op);
    assign lane_sel = rm_lane_sel(op_q, req_mask);

    rotmerge_rotator #(
        .WORD_W (WORD_W),
        .ROT_W  (ROT_W)
    ) u_rot (
        .data_in  (src_word),
        .amount   (req_rot),
        .data_out (rot_word)
    );

    rotmerge_lane_merge #(
        .WORD_W (WORD_W),
        .LANE_W (LANE_W),
        .LANES  (LANES)
    ) u_merge (
        .take_word (rot_word),
        .keep_word (dst_word),
        .lane_sel  (lane_sel),
        .merged    (merge_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_r <= 1'b0;
            word_r  <= '0;
        end else begin
            valid_r <= req_valid;
            if (req_valid) begin
                word_r <= merge_word;
            end
        end
    end

    assign res_valid = valid_r;
    assign res_word  = word_r;

    // R7
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);

    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(res_word)));

    // R2
    move_ones_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_q == OP_MOVE) |=> ($countones(res_word) == $countones($past(src_word))));

    // R3
    rot_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_q == OP_MOVE && req_rot == '0) |=> (res_word == $past(src_word)));

    // R5
    mask_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && op_q == OP_FIELD && req_mask == '0) |=> (res_word == $past(dst_word)));

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        // R4
        lane_keep_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid && op_q == OP_FIELD && !req_mask[l])
            |=> (res_word[l*LANE_W +: LANE_W] == $past(dst_word[l*LANE_W +: LANE_W])));
        // R4
        lane_take_chk: assert property (@(posedge clk) disable iff (rst)
            (req_valid && req_mask[l])
            |=> (res_word[l*LANE_W +: LANE_W] == $past(rot_word[l*LANE_W +: LANE_W])));
    end

endmodule

// File: tb/rotmerge_unit_test.sv
`timescale 1ns/1ps
module rotmerge_unit_test;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic        req_op;
    logic [4:0]  req_rot;
    logic [3:0]  req_mask;
    logic [31:0] src_word;
    logic [31:0] dst_word;
    logic        res_valid;
    logic [31:0] res_word;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    rotmerge_unit uut (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_op    (req_op),
        .req_rot   (req_rot),
        .req_mask  (req_mask),
        .src_word  (src_word),
        .dst_word  (dst_word),
        .res_valid (res_valid),
        .res_word  (res_word)
    );

    function automatic logic [31:0] ref_rotl(input logic [31:0] x, input int r);
        logic [31:0] y;
        for (int i = 0; i < 32; i++) y[(i + r) % 32] = x[i];
        return y;
    endfunction

    function automatic logic [31:0] ref_field(input logic [31:0] s, input int r,
                                              input logic [3:0] m, input logic [31:0] d);
        logic [31:0] rs = ref_rotl(s, r);
        logic [31:0] y  = d;
        for (int l = 0; l < 4; l++) if (m[l]) y[l*8 +: 8] = rs[l*8 +: 8];
        return y;
    endfunction

    function automatic logic [31:0] ref_rev(input logic [31:0] x);
        return {x[7:0], x[15:8], x[23:16], x[31:24]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic op, input int rot, input logic [3:0] m,
                         input logic [31:0] s, input logic [31:0] d);
        req_valid = 1'b1;
        req_op    = op;
        req_rot   = 5'(rot);
        req_mask  = m;
        src_word  = s;
        dst_word  = d;
    endtask

    // One request, result sampled at the next falling edge.
    task automatic do_op(input logic op, input int rot, input logic [3:0] m,
                         input logic [31:0] s, input logic [31:0] d,
                         output logic [31:0] r);
        @(negedge clk);
        drive(op, rot, m, s, d);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R7 valid", {31'd0, res_valid}, 32'd1);
        r = res_word;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        req_valid = 1'b0; req_op = 1'b0; req_rot = '0; req_mask = '0;
        src_word = '0; dst_word = '0;
        repeat (3) @(negedge clk);
        chk("R1 valid", {31'd0, res_valid}, 32'd0);
        chk("R1 word", res_word, 32'd0);
        rst = 1'b0;
    endtask

    task automatic t_move_all_rot();
        logic [31:0] r;
        for (int a = 0; a < 32; a++) begin
            do_op(1'b0, a, 4'b0000, 32'h0000_0001, 32'hFFFF_FFFF, r);
            chk("R3 single bit", r, ref_rotl(32'h0000_0001, a));
            do_op(1'b0, a, 4'(a), 32'h1234_5678, 32'hDEAD_BEEF, r);
            chk("R2 move", r, ref_rotl(32'h1234_5678, a));
        end
        do_op(1'b0, 0, 4'b1010, 32'hCAFE_F00D, 32'h0, r);
        chk("R3 rot zero", r, 32'hCAFE_F00D);
    endtask

    task automatic t_field_masks();
        logic [31:0] r;
        for (int m = 0; m < 16; m++) begin
            do_op(1'b1, 8, 4'(m), 32'hA1B2_C3D4, 32'h5566_7788, r);
            chk("R4 field", r, ref_field(32'hA1B2_C3D4, 8, 4'(m), 32'h5566_7788));
        end
        do_op(1'b1, 24, 4'b1010, 32'h1122_3344, 32'hEEEE_EEEE, r);
        chk("R4 mask 1010", r, 32'h44EE_22EE);
    endtask

    task automatic t_mask_edges();
        logic [31:0] r, mv;
        do_op(1'b1, 13, 4'b0000, 32'h0F0F_1234, 32'h9876_5432, r);
        chk("R5 mask zero", r, 32'h9876_5432);
        do_op(1'b1, 13, 4'b1111, 32'h0F0F_1234, 32'h9876_5432, r);
        do_op(1'b0, 13, 4'b0000, 32'h0F0F_1234, 32'h0, mv);
        chk("R6 full mask", r, mv);
        chk("R6 full mask ref", r, ref_rotl(32'h0F0F_1234, 13));
    endtask

    task automatic t_back_to_back();
        @(negedge clk);
        drive(1'b0, 4, 4'b0000, 32'h8000_0001, 32'h0);
        @(negedge clk);
        chk("R7 b2b valid 1", {31'd0, res_valid}, 32'd1);
        chk("R7 b2b word 1", res_word, 32'h0000_0018);
        drive(1'b1, 0, 4'b0001, 32'h0000_00AB, 32'h1111_1111);
        @(negedge clk);
        chk("R7 b2b valid 2", {31'd0, res_valid}, 32'd1);
        chk("R7 b2b word 2", res_word, 32'h1111_11AB);
        req_valid = 1'b0;
    endtask

    task automatic t_idle_hold();
        logic [31:0] r;
        do_op(1'b0, 0, 4'b0000, 32'h7777_0001, 32'h0, r);
        for (int i = 0; i < 3; i++) begin
            req_op = 1'(i); req_rot = 5'(i + 3); req_mask = 4'b1111;
            src_word = 32'h0BAD_0000 + i; dst_word = 32'hFFFF_0000 - i;
            @(negedge clk);
            chk("R8 idle valid", {31'd0, res_valid}, 32'd0);
            chk("R8 idle hold", res_word, 32'h7777_0001);
        end
    endtask

    task automatic t_swap_random();
        logic [31:0] s, r1, r2;
        for (int i = 0; i < 40; i++) begin
            s = $urandom();
            do_op(1'b0, 8, 4'b0000, s, $urandom(), r1);
            do_op(1'b1, 24, 4'b1010, s, r1, r2);
            chk("R9 swap", r2, ref_rev(s));
        end
        do_op(1'b0, 8, 4'b0000, 32'h0102_0304, 32'h0, r1);
        do_op(1'b1, 24, 4'b1010, 32'h0102_0304, r1, r2);
        chk("R9 swap fixed", r2, 32'h0403_0201);
    endtask

    initial begin
        t_reset();
        t_move_all_rot();
        t_field_masks();
        t_mask_edges();
        t_back_to_back();
        t_idle_hold();
        t_swap_random();
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule